// File: doc/BRIEF.md
# Receive FIFO with Fill Threshold and Idle Timeout

This block buffers 9-bit words that arrive from a serial receiver's shift register in a 16-entry first-in first-out store. The host sees the oldest stored word on the read port at all times and pops it with a read strobe. A ready indication goes high once a programmable number of words is stored, so the host can service the receiver in batches instead of word by word.

A partial batch would otherwise sit in the store indefinitely. To prevent this, an idle timer counts bit-time ticks while the store holds data and nothing moves. After nine such ticks with no arrival and no read, an idle event is latched. That event also raises the ready indication, which flushes the remainder to the host. Either cause of ready can drive the receive interrupt when it is enabled. A write that meets a full store is discarded and leaves a sticky overrun mark.

Top module: `rx_fifo_idle`

## Requirements
- R1: Accepted words come out in arrival order. `rd_data` shows the oldest stored word whenever `count` is non-zero. `count` holds the number of stored words (0 to 16). A read strobe while `count` is 0 changes nothing.
- R2: A write strobe while `count` is 16 stores nothing. `overrun` then goes high on the next cycle and stays high until reset.
- R3: `rx_ready` is high whenever `count` is non-zero and not below `thresh`. A `thresh` of 0 acts as 1.
- R4: While `count` is non-zero and no word is accepted or read, the ninth `bit_tick` sets `idle_flag` (provided `idle_en` is 1). Once set, `rx_ready` stays high whatever the threshold.
- R5: Every accepted write, every accepted read and an empty store restart the idle timer. An accepted read or an empty store clears `idle_flag`.
- R6: While `idle_en` is 0, `idle_flag` is low one cycle later and no idle event is produced.
- R7: `irq` equals `rx_ready` while `rx_irq_en` is 1 and is low while it is 0, in the same cycle.
- R8: After reset, `count` is 0 and `rx_ready`, `idle_flag`, `overrun` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Word arrives from the shift register |
| wr_data | input | 9 | Arriving word |
| rd_en | input | 1 | Host pops the oldest word |
| bit_tick | input | 1 | One pulse per serial bit time |
| thresh | input | 5 | Fill level that raises ready (0 treated as 1) |
| idle_en | input | 1 | Enables idle detection |
| rx_irq_en | input | 1 | Enables the receive interrupt |
| rd_data | output | 9 | Oldest stored word |
| count | output | 5 | Number of stored words |
| rx_ready | output | 1 | Threshold reached or idle event pending |
| idle_flag | output | 1 | Idle event latched |
| overrun | output | 1 | Sticky: a word was dropped on a full store |
| irq | output | 1 | Receive interrupt request |

## Verification
The strobes sampled at one rising edge update `count`, `rd_data`, `overrun` and `idle_flag` at that same edge, so each is due one cycle after the stimulus. `rx_ready` and `irq` follow combinationally from the registered state and from `thresh`/`rx_irq_en`, so they are due in the same cycle. The bench drives inputs at the falling edge and updates its reference model at the rising edge. It compares every output at the next falling edge, which is where all these latencies have settled. Directed sequences place the ninth tick, the full-store write and the idle-disable exactly, so that the timer boundary is checked at both eight and nine ticks.

// File: rtl/rx_fifo_idle.sv
module rx_fifo_idle #(
  parameter int DW        = 9,
  parameter int DEPTH     = 16,
  parameter int IDLE_BITS = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int TW = $clog2(IDLE_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          bit_tick,
  input  logic [AW:0]   thresh,
  input  logic          idle_en,
  input  logic          rx_irq_en,
  output logic [DW-1:0] rd_data,
  output logic [AW:0]   count,
  output logic          rx_ready,
  output logic          idle_flag,
  output logic          overrun,
  output logic          irq
);
  localparam logic [AW:0]   FULLC = (AW+1)'(DEPTH);
  localparam logic [TW-1:0] TMAX  = TW'(IDLE_BITS);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [TW-1:0] tmr;
  logic          acc_wr, acc_rd, empty;

  assign empty  = (count == '0);
  assign acc_wr = wr_en && (count != FULLC);
  assign acc_rd = rd_en && !empty;

  always_ff @(posedge clk)
    if (acc_wr) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; overrun <= 1'b0;
    end else begin
      if (acc_wr) wp <= wp + 1'b1;
      if (acc_rd) rp <= rp + 1'b1;
      if (acc_wr && !acc_rd) count <= count + 1'b1;
      else if (acc_rd && !acc_wr) count <= count - 1'b1;
      if (wr_en && !acc_wr) overrun <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmr <= '0; idle_flag <= 1'b0;
    end else begin
      if (acc_wr || acc_rd || empty) tmr <= '0;
      else if (bit_tick && tmr != TMAX) tmr <= tmr + 1'b1;
      if (!idle_en || acc_rd || empty) idle_flag <= 1'b0;
      else if (bit_tick && tmr == TMAX && !acc_wr) idle_flag <= 1'b1;
    end

  assign rd_data  = mem[rp];
  assign rx_ready = (!empty && (count >= thresh)) || idle_flag;
  assign irq      = rx_irq_en && rx_ready;
endmodule

// File: rtl/rx_fifo_idle_chk.sv
module rx_fifo_idle_chk #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic        idle_en,
  input logic        rx_irq_en,
  input logic [AW:0] count,
  input logic        rx_ready,
  input logic        idle_flag,
  input logic        overrun,
  input logic        irq
);
  localparam logic [AW:0] FULLC = (AW+1)'(DEPTH);

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLC);

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> ((count == $past(count) + 1'b1) || (count + 1'b1 == $past(count))));

  // R2
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULLC && wr_en && !rd_en) |=> (count == FULLC && overrun));

  // R6
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_en |=> !idle_flag);

  // R5
  idle_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_flag |-> (count != '0));

  // R3
  ready_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !rx_ready);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_irq_en && rx_ready));
endmodule

bind rx_fifo_idle rx_fifo_idle_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .idle_en(idle_en),
  .rx_irq_en(rx_irq_en), .count(count), .rx_ready(rx_ready),
  .idle_flag(idle_flag), .overrun(overrun), .irq(irq)
);

// File: tb/rx_fifo_idle_bench.sv
module rx_fifo_idle_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, bit_tick = 0, idle_en = 1, rx_irq_en = 1;
  logic [8:0] wr_data = '0;
  logic [4:0] thresh = 5'd4;
  logic [8:0] rd_data;
  logic [4:0] count;
  logic rx_ready, idle_flag, overrun, irq;

  int checks = 0, errors = 0;
  logic [8:0] q[$];
  int m_tmr = 0;
  bit m_idle = 0, m_ovr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_idle u_rx_fifo_idle (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .bit_tick(bit_tick), .thresh(thresh), .idle_en(idle_en), .rx_irq_en(rx_irq_en),
    .rd_data(rd_data), .count(count), .rx_ready(rx_ready), .idle_flag(idle_flag),
    .overrun(overrun), .irq(irq)
  );

  always @(posedge clk) if (rst_n) begin
    int s; bit aw, ar; int t0;
    s = q.size(); t0 = m_tmr;
    aw = wr_en && s < 16; ar = rd_en && s > 0;
    if (ar) void'(q.pop_front());
    if (aw) q.push_back(wr_data);
    if (wr_en && s == 16) m_ovr = 1;
    if (aw || ar || s == 0) m_tmr = 0;
    else if (bit_tick && t0 < 8) m_tmr = t0 + 1;
    if (!idle_en || ar || s == 0) m_idle = 0;
    else if (bit_tick && t0 == 8 && !aw) m_idle = 1;
  end

  function automatic bit exp_ready();
    int th = (thresh == 0) ? 1 : int'(thresh);
    return (q.size() != 0 && q.size() >= th) || m_idle;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(count == q.size(), "R1 count", count, q.size());
    if (q.size() != 0) chk(rd_data == q[0], "R1 rd_data", rd_data, q[0]);
    chk(overrun == m_ovr, "R2 overrun", overrun, m_ovr);
    chk(rx_ready == exp_ready(), "R3 rx_ready", rx_ready, exp_ready());
    chk(idle_flag == m_idle, "R4 idle_flag", idle_flag, m_idle);
    chk(irq == (rx_irq_en && exp_ready()), "R7 irq", irq, rx_irq_en && exp_ready());
  endtask

  task automatic step(bit w, bit r, bit t);
    wr_en = w; rd_en = r; bit_tick = t; wr_data = 9'($urandom);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(count == 0, "R8 count", count, 0);
    chk(!rx_ready && !idle_flag && !overrun && !irq, "R8 flags",
        {rx_ready, idle_flag, overrun, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 read on empty store is ignored
    step(0, 1, 0);
    chk(count == 0, "R1 empty read", count, 0);

    // R4 R5 idle boundary: 8 ticks no event, 9th sets it
    thresh = 5'd8;
    step(1, 0, 0); step(1, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 1);
    chk(!idle_flag, "R4 eight ticks", idle_flag, 0);
    step(0, 0, 1);
    chk(idle_flag && rx_ready, "R4 ninth tick", {idle_flag, rx_ready}, 3);
    step(0, 1, 0);
    chk(!idle_flag, "R5 read clears idle", idle_flag, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 1);
    step(1, 0, 0); // R5 write restarts the timer
    for (int i = 0; i < 8; i++) step(0, 0, 1);
    chk(!idle_flag, "R5 timer restarted", idle_flag, 0);

    // R6 idle detection disabled
    idle_en = 0;
    for (int i = 0; i < 12; i++) step(0, 0, 1);
    chk(!idle_flag, "R6 disabled", idle_flag, 0);
    idle_en = 1;
    step(0, 0, 1);
    chk(idle_flag, "R6 re-enabled fires", idle_flag, 1);

    // R2 fill past full, then drain
    thresh = 5'd0;
    for (int i = 0; i < 18; i++) step(1, 0, 0);
    chk(count == 16 && overrun, "R2 full drop", count, 16);
    step(1, 1, 0);
    chk(count == 15, "R2 full write with read", count, 15);
    rx_irq_en = 0;
    step(0, 0, 0);
    chk(!irq, "R7 masked", irq, 0);
    rx_irq_en = 1;
    while (count != 0) step(0, 1, 0);
    chk(overrun, "R2 sticky after drain", overrun, 1);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 49) == 0) thresh = 5'($urandom_range(0, 16));
      idle_en   = ($urandom_range(0, 19) != 0);
      rx_irq_en = ($urandom_range(0, 3) != 0);
      step($urandom_range(0, 99) < (i % 400 < 200 ? 45 : 8),
           $urandom_range(0, 99) < (i % 400 < 200 ? 25 : 10),
           $urandom_range(0, 2) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule